// File: doc/BRIEF.md
# Test-port instruction register with data-register routing

This block holds the instruction register of an IEEE 1149.1 test port. It works out which data register sits in the serial path between `tdi` and `tdo`. An external test-port state machine drives the capture, shift and update strobes for the instruction path and for the data path. The block does all of its shifting on the rising edge of `tck`. It changes the serial output only on the falling edge.

The block holds two data registers of its own:

- a 1-bit bypass stage;
- a 32-bit identification register, built from parameters.

The boundary chain is outside the block. The block gives that chain gated capture, shift and update enables, and it takes the chain's serial output back on `bsr_so`.

The "float pins" instruction routes the bypass stage into the path. While that instruction is active, the block also asks for every I/O output driver to be released.

Top module: `jtag_ir_decode`

## Requirements
- R1: The instruction register is 10 bits wide. It is loaded serially from `tdi`, least significant bit first, while `shift_ir` is high. The loaded value shows on `active_ir` only after a cycle with `update_ir` high.
- R2: A cycle with `capture_ir` high preloads the shift stage with 10'b00_0000_0001. The following shifts send that pattern out on `tdo`, least significant bit first.
- R3: Instruction 10'h00B (float pins) selects the bypass stage. While it is the active instruction, `highz_req` is 1.
- R4: The bypass stage is one bit long. It captures 0 on `capture_dr`, and each `shift_dr` cycle delays `tdi` by exactly one shift.
- R5: The identification register holds {version[3:0], part[15:0], maker[10:0], 1'b1}, with bit 0 always 1. It is loaded on `capture_dr` and shifted out least significant bit first.
- R6: The routing, `highz_req` and `bsr_sel` follow only the updated instruction. Shifting a new code in, without an update, changes none of them.
- R7: While `trst_n` is low, the active instruction becomes 10'h006 (identification). `highz_req` is then 0.
- R8: Instruction 10'h3FF and every code not listed in R3, R7 or R9 select the bypass stage, with `highz_req` at 0.
- R9: Codes 10'h005 and 10'h00F select the boundary chain. `bsr_sel` is then 1, `bsr_capture`/`bsr_shift`/`bsr_update` follow `capture_dr`/`shift_dr`/`update_dr`, and `tdo` carries `bsr_so`. When the chain is not selected, all three enables stay 0.
- R10: `tdo` changes only on the falling edge of `tck`. Just after a rising edge it still shows the bit launched on the previous falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-logic reset, active low, asynchronous |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | Instruction capture strobe |
| shift_ir | input | 1 | Instruction shift strobe |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data capture strobe |
| shift_dr | input | 1 | Data shift strobe |
| update_dr | input | 1 | Data update strobe |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| active_ir | output | 10 | Updated instruction in use |
| highz_req | output | 1 | Request to release all I/O output drivers |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Gated capture enable for the boundary chain |
| bsr_shift | output | 1 | Gated shift enable for the boundary chain |
| bsr_update | output | 1 | Gated update enable for the boundary chain |

## Verification
Each code is shifted in with `update_ir` held back, and the bench checks that `highz_req` and `active_ir` do not move. A design that decoded the shifting copy would glitch pin release partway through a scan.

The bypass path is checked for a delay of exactly one bit. A zero-delay or two-stage bypass would shift the pattern the wrong way.

The identification scan is checked for a captured bit 0 of 1 and for the falling-edge launch of `tdo`. A design that launched on the rising edge would show the next bit too early.

Unknown and all-ones codes must fall back to the bypass stage. The reset check confirms that a pending float-pins instruction is dropped in favour of identification.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;
  localparam int IR_W = 10;
  localparam int ID_W = 32;

  typedef enum logic [1:0] {DR_BYP = 2'd0, DR_ID = 2'd1, DR_BSR = 2'd2} dr_sel_e;

  localparam logic [IR_W-1:0] OP_HIGHZ  = 10'h00B;
  localparam logic [IR_W-1:0] OP_IDCODE = 10'h006;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST = 10'h00F;
  localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;
  localparam logic [IR_W-1:0] IR_CAPT   = 10'h001;

  // Routing for an updated instruction; anything unknown falls to bypass.
  function automatic dr_sel_e op_route(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:            return DR_ID;
      OP_SAMPLE, OP_EXTEST: return DR_BSR;
      default:              return DR_BYP;
    endcase
  endfunction

  function automatic logic op_floats(input logic [IR_W-1:0] op);
    return op == OP_HIGHZ;
  endfunction

  function automatic logic [ID_W-1:0] pack_idcode(input logic [3:0] ver,
                                                  input logic [15:0] part,
                                                  input logic [10:0] maker);
    return {ver, part, maker, 1'b1};
  endfunction
endpackage

// File: rtl/jtag_ir_stage.sv
module jtag_ir_stage #(
  parameter int W = 10,
  parameter logic [W-1:0] CAPT = '0,
  parameter logic [W-1:0] RST_OP = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         cap,
  input  logic         sh,
  input  logic         upd,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      shift_q  <= CAPT;
      active_q <= RST_OP;
    end else begin
      if (cap)      shift_q <= CAPT;
      else if (sh)  shift_q <= {tdi, shift_q[W-1:1]};
      if (upd)      active_q <= shift_q;
    end
  end
endmodule

// File: rtl/jtag_ir_route.sv
module jtag_ir_route
  import jtag_ir_pkg::*;
(
  input  logic [IR_W-1:0] op,
  output dr_sel_e         route,
  output logic            float_req
);
  always_comb begin
    route     = op_route(op);
    float_req = op_floats(op);
  end
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_ir_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VAL = 32'h0000_0001
) (
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tdi,
  input  logic    cap,
  input  logic    sh,
  input  dr_sel_e route,
  input  logic    bsr_so,
  output logic    byp_q,
  output logic    dr_so
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (route == DR_BYP) begin
        if (cap)     byp_q <= 1'b0;
        else if (sh) byp_q <= tdi;
      end
      if (route == DR_ID) begin
        if (cap)     id_q <= ID_VAL;
        else if (sh) id_q <= {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    case (route)
      DR_ID:   dr_so = id_q[0];
      DR_BSR:  dr_so = bsr_so;
      default: dr_so = byp_q;
    endcase
  end
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
  import jtag_ir_pkg::*;
#(
  parameter logic [3:0]  ID_VER   = 4'h1,
  parameter logic [15:0] ID_PART  = 16'h3A5C,
  parameter logic [10:0] ID_MAKER = 11'h0AA
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            bsr_so,
  output logic            tdo,
  output logic [IR_W-1:0] active_ir,
  output logic            highz_req,
  output logic            bsr_sel,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update
);
  localparam logic [ID_W-1:0] ID_VAL = pack_idcode(ID_VER, ID_PART, ID_MAKER);

  logic [IR_W-1:0] ir_shift_q;
  dr_sel_e         route;
  logic            byp_q;
  logic            dr_so;

  jtag_ir_stage #(.W(IR_W), .CAPT(IR_CAPT), .RST_OP(OP_IDCODE)) u_stage (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap(capture_ir), .sh(shift_ir),
    .upd(update_ir), .shift_q(ir_shift_q), .active_q(active_ir)
  );

  jtag_ir_route u_route (.op(active_ir), .route(route), .float_req(highz_req));

  jtag_dr_bank #(.ID_VAL(ID_VAL)) u_bank (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap(capture_dr), .sh(shift_dr),
    .route(route), .bsr_so(bsr_so), .byp_q(byp_q), .dr_so(dr_so)
  );

  always_comb begin
    bsr_sel     = (route == DR_BSR);
    bsr_capture = bsr_sel & capture_dr;
    bsr_shift   = bsr_sel & shift_dr;
    bsr_update  = bsr_sel & update_dr;
  end

  // Serial output launched on the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)       tdo <= 1'b0;
    else if (shift_ir) tdo <= ir_shift_q[0];
    else               tdo <= dr_so;
  end
endmodule

// File: rtl/jtag_ir_checker.sv
module jtag_ir_checker
  import jtag_ir_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tdi,
  input logic            capture_ir,
  input logic            update_ir,
  input logic            shift_dr,
  input logic            capture_dr,
  input logic [IR_W-1:0] active_ir,
  input logic [IR_W-1:0] ir_shift_q,
  input logic            highz_req,
  input logic            bsr_sel,
  input logic            bsr_shift,
  input logic            bsr_capture,
  input logic            byp_q,
  input dr_sel_e         route
);
  a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    capture_ir |=> ir_shift_q == IR_CAPT);

  a_r6_hold_without_update: assert property (@(posedge tck) disable iff (!trst_n)
    !update_ir |=> $stable(active_ir));

  a_r3_highz_no_chain_shift: assert property (@(posedge tck) disable iff (!trst_n)
    highz_req |-> !bsr_shift && !bsr_capture);

  a_r4_bypass_one_delay: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr && route == DR_BYP) |=> byp_q == $past(tdi));

  a_r9_enables_need_select: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_shift || bsr_capture) |-> bsr_sel);
endmodule

bind jtag_ir_decode jtag_ir_checker u_chk (
  .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_ir(capture_ir),
  .update_ir(update_ir), .shift_dr(shift_dr), .capture_dr(capture_dr),
  .active_ir(active_ir), .ir_shift_q(ir_shift_q), .highz_req(highz_req),
  .bsr_sel(bsr_sel), .bsr_shift(bsr_shift), .bsr_capture(bsr_capture),
  .byp_q(byp_q), .route(route)
);

// File: tb/jtag_ir_decode_bench.sv
module jtag_ir_decode_bench;
  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic bsr_so;
  logic tdo, highz_req, bsr_sel, bsr_capture, bsr_shift, bsr_update;
  logic [9:0] active_ir;
  int checks = 0, errors = 0;

  localparam logic [31:0] EXP_ID = {4'h1, 16'h3A5C, 11'h0AA, 1'b1};

  always #5 tck = ~tck;
  assign bsr_so = ~tdi;

  jtag_ir_decode u_jtag_ir_decode (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .bsr_so(bsr_so), .tdo(tdo),
    .active_ir(active_ir), .highz_req(highz_req), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update)
  );

  // {code, kind (0 bypass, 1 id, 2 chain), float}
  localparam int NV = 7;
  localparam logic [12:0] VEC [NV] = '{
    {10'h00B, 2'd0, 1'b1}, {10'h006, 2'd1, 1'b0}, {10'h005, 2'd2, 1'b0},
    {10'h00F, 2'd2, 1'b0}, {10'h3FF, 2'd0, 1'b0}, {10'h2A7, 2'd0, 1'b0},
    {10'h00B, 2'd0, 1'b1}};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck); #2;
  endtask

  task automatic shift_bit(input logic b, output logic o);
    tdi = b;
    @(negedge tck); #1 o = tdo;
    @(posedge tck); #2;
  endtask

  task automatic load_ir(input logic [9:0] code, output logic [9:0] cap_out,
                         output bit held);
    logic [9:0] ir0;
    logic hz0, o;
    ir0 = active_ir; hz0 = highz_req; held = 1;
    capture_ir = 1; tick(); capture_ir = 0;
    shift_ir = 1;
    for (int i = 0; i < 10; i++) begin
      shift_bit(code[i], o);
      cap_out[i] = o;
      if (active_ir !== ir0 || highz_req !== hz0) held = 0;
    end
    shift_ir = 0;
    if (active_ir !== ir0 || highz_req !== hz0) held = 0;
    update_ir = 1; tick(); update_ir = 0;
  endtask

  task automatic scan_dr(input int n, input logic [31:0] pat, output logic [31:0] got,
                         output bit chain_en);
    logic o;
    got = '0; chain_en = 1;
    capture_dr = 1; tick(); capture_dr = 0;
    shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = pat[i];
      #1 if (bsr_shift !== bsr_sel) chain_en = 0;
      shift_bit(pat[i], o);
      got[i] = o;
    end
    shift_dr = 0;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [9:0] capv;
    logic [31:0] got, exp;
    bit held, en;
    logic o;
    repeat (3) @(posedge tck);
    #2 trst_n = 1;
    tick();
    // R7: reset state
    check(active_ir == 10'h006, "R7 reset instruction", active_ir, 10'h006);
    check(highz_req == 0 && bsr_sel == 0, "R7 reset float/select", {highz_req, bsr_sel}, 0);
    // R5 full identification scan, R10 falling-edge launch
    capture_dr = 1; tick(); capture_dr = 0;
    shift_dr = 1; got = '0;
    for (int i = 0; i < 32; i++) begin
      shift_bit(1'b0, o);
      got[i] = o;
      if (i == 0) check(tdo == 1'b1, "R10 tdo held past rising edge", tdo, 1);
    end
    shift_dr = 0;
    check(got == EXP_ID, "R5 identification value", got, EXP_ID);
    check(got[0] == 1'b1, "R5 bit0 fixed one", got[0], 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [9:0] code;
      logic [1:0] kind;
      logic hz;
      {code, kind, hz} = VEC[v];
      load_ir(code, capv, held);
      check(capv == 10'h001, "R2 captured pattern", capv, 10'h001);
      check(held, "R6 no change while shifting", held, 1);
      check(active_ir == code, "R1 updated instruction", active_ir, code);
      check(highz_req == hz, "R3/R8 float request", highz_req, hz);
      check(bsr_sel == (kind == 2), "R9 chain select", bsr_sel, kind == 2);
      scan_dr(4, 32'b1101, got, en);
      case (kind)
        2'd0: exp = 32'b1010;
        2'd1: exp = {28'd0, EXP_ID[3:0]};
        default: exp = 32'b0010;
      endcase
      check(got == exp, kind == 0 ? "R4/R8 bypass path" :
                        kind == 1 ? "R5 identification path" : "R9 chain path", got, exp);
      check(en, "R9 shift enable gating", en, 1);
      update_dr = 1; #1
      check(bsr_update == (kind == 2), "R9 update enable", bsr_update, kind == 2);
      tick(); update_dr = 0;
    end

    // R7: reset clears a float request
    check(highz_req == 1, "R3 float active before reset", highz_req, 1);
    trst_n = 0; #3;
    check(highz_req == 0 && active_ir == 10'h006, "R7 reset drops float",
          {highz_req, active_ir}, 10'h006);
    tick(); trst_n = 1; tick();
    finish_run();
  end
endmodule